// File: doc/BRIEF.md
# Polled Service Request Context Controller

This block sits between the four channels of a serial controller and a CPU that services them by polling. Each channel can raise three kinds of service request: receive, transmit and modem. For each kind the block picks one requesting channel, latches it in a per-type request register, and drives that type's active-low request pin. A master status register shows all three pending flags in one read.

Software services a request by reading a request register and writing the same byte into the channel access register. That write opens a service context for that type and channel, with the same effect as a hardware acknowledge. While the context is open, a context view register reads valid data. Software closes the context by writing the byte back with its top two bits cleared. The request is then released, and the type may latch a new channel.

A two-state machine tracks the context. In `S_IDLE` no context is open. The transition *switch* moves it to `S_SERVE` when the write matches a latched request. In `S_SERVE` one context is open. The transition *close* returns it to `S_IDLE` when the write matches the cleared form of that context's request. Every other write leaves the state as it is.

Top module: `svc_poll_ctx`

## Requirements
- R1: After reset all three request pins are high, `ctx_active` is 0, and the status, request, access and view registers read 0x00, except the view register, which reads 0xFF.
- R2: A type's request pin goes low on the first clock edge at which any channel of that type requests service, and stays low while that type has a latched request.
- R3: The status register (address 0) reads bit 0 = receive pending, bit 1 = transmit pending and bit 2 = modem pending, each the inverse of its pin. Bits 7:3 read 0.
- R4: The request registers sit at address 1 (receive), 2 (transmit) and 3 (modem). Each reads bit 7 = request latched, bit 6 = context open for this type, bit 5 = 0, bits 4:2 = type code (receive 001, transmit 010, modem 100) and bits 1:0 = channel. The register reads 0x00 when nothing is latched.
- R5: The lowest-numbered requesting channel is latched. The latched channel does not change until its context closes, even if its request drops or a lower channel starts requesting.
- R6: With no context open, a write to the channel access register (address 4) equal to a latched request register value opens the context. From the next cycle `ctx_active`=1, `ctx_type` shows the type (0 receive, 1 transmit, 2 modem), `ctx_chan` shows the channel, and address 4 reads back the written byte.
- R7: With no context open, an access-register write that matches no latched request register leaves the block idle.
- R8: While a context is open, a write of a request value (bit 7 set) to the access register is ignored. Type and channel are unchanged.
- R9: While a context is open, writing its request value with bits 7:6 cleared closes it and clears that type's latch, so the pin goes high. Any channel of that type still requesting is latched one cycle later. Any other access-register byte leaves the context open.
- R10: The context view register (address 5) reads 0xFF when no context is open. Inside a context it reads {000, type code, channel}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_chan_req | input | 4 | Receive service request, one bit per channel |
| tx_chan_req | input | 4 | Transmit service request, one bit per channel |
| mdm_chan_req | input | 4 | Modem service request, one bit per channel |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational from address) |
| rx_req_n | output | 1 | Receive request pin, active low |
| tx_req_n | output | 1 | Transmit request pin, active low |
| mdm_req_n | output | 1 | Modem request pin, active low |
| ctx_active | output | 1 | A service context is open |
| ctx_type | output | 2 | Type of the open context |
| ctx_chan | output | 2 | Channel of the open context |

## Verification
The assertions check several rules on every cycle: the status bits mirror the pins, the view register reads 0xFF outside a context, an open context's type keeps its pin low, and type and channel stay put while no access write occurs or while a second switch is attempted. Other behaviour needs the bench's directed scenarios: which channel wins the priority, that the latch holds after requests change, the exact request byte that opens a context, the cleared byte that closes it, and the relatch one cycle after close.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int NTYPE = 3;
    localparam int DW    = 8;

    typedef enum logic [1:0] {
        T_RX  = 2'd0,
        T_TX  = 2'd1,
        T_MDM = 2'd2
    } svc_type_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_SERVE = 1'b1
    } ctx_state_e;

    localparam logic [2:0] A_STATUS = 3'd0;
    localparam logic [2:0] A_RXREQ  = 3'd1;
    localparam logic [2:0] A_TXREQ  = 3'd2;
    localparam logic [2:0] A_MDMREQ = 3'd3;
    localparam logic [2:0] A_CAR    = 3'd4;
    localparam logic [2:0] A_VIEW   = 3'd5;

    localparam logic [DW-1:0] VIEW_UNDEF = 8'hFF;

    function automatic logic [2:0] type_code(input int t);
        return 3'(1 << t);
    endfunction
endpackage

// File: rtl/svc_req_latch.sv
module svc_req_latch
    import svc_pkg::*;
#(
    parameter int         NCH  = 4,
    parameter logic [2:0] CODE = 3'b001
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_req,
    input  logic           release_i,
    input  logic           open_i,
    output logic           valid_o,
    output logic [1:0]     chan_o,
    output logic [DW-1:0]  reg_o
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic           valid_q;
    logic [CHW-1:0] chan_q;
    logic [CHW-1:0] pick;
    logic           any_req;

    // lowest-numbered requesting channel wins
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_req[i]) pick = CHW'(i);
        end
    end

    assign any_req = |chan_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            chan_q  <= '0;
        end else if (release_i) begin
            valid_q <= 1'b0;
        end else if (!valid_q && any_req) begin
            valid_q <= 1'b1;
            chan_q  <= pick;
        end
    end

    assign valid_o = valid_q;
    assign chan_o  = 2'(chan_q);
    assign reg_o   = valid_q ? {1'b1, open_i, 1'b0, CODE, 2'(chan_q)} : '0;
endmodule

// File: rtl/svc_ctx_fsm.sv
module svc_ctx_fsm
    import svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             car_wr,
    input  logic [DW-1:0]    wdata,
    input  logic [NTYPE-1:0] hit,
    input  logic             end_match,
    output logic             active_o,
    output logic             close_o,
    output svc_type_e        type_o,
    output logic [1:0]       chan_o,
    output logic [DW-1:0]    car_o
);
    ctx_state_e state_q, state_d;
    svc_type_e  type_q;
    logic [1:0] chan_q;
    logic [DW-1:0] car_q;
    logic       do_switch;
    logic       do_close;
    svc_type_e  hit_type;

    always_comb begin
        hit_type = T_RX;
        if (hit[1]) hit_type = T_TX;
        if (hit[2]) hit_type = T_MDM;
    end

    always_comb begin
        state_d   = state_q;
        do_switch = 1'b0;
        do_close  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (car_wr && (|hit)) begin
                    do_switch = 1'b1;
                    state_d   = S_SERVE;
                end
            end
            S_SERVE: begin
                if (car_wr && end_match) begin
                    do_close = 1'b1;
                    state_d  = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= T_RX;
            chan_q <= '0;
            car_q  <= '0;
        end else if (do_switch) begin
            type_q <= hit_type;
            chan_q <= wdata[1:0];
            car_q  <= wdata;
        end
    end

    always_comb begin
        active_o = (state_q == S_SERVE);
        close_o  = do_close;
        type_o   = type_q;
        chan_o   = chan_q;
        car_o    = active_o ? car_q : '0;
    end
endmodule

// File: rtl/svc_read_mux.sv
module svc_read_mux
    import svc_pkg::*;
(
    input  logic [2:0]       addr,
    input  logic [NTYPE-1:0] pending,
    input  logic [DW-1:0]    rx_reg,
    input  logic [DW-1:0]    tx_reg,
    input  logic [DW-1:0]    mdm_reg,
    input  logic [DW-1:0]    car_val,
    input  logic             active,
    input  logic [2:0]       ctx_code,
    input  logic [1:0]       ctx_chan,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_STATUS: rdata = {{(DW-NTYPE){1'b0}}, pending};
            A_RXREQ:  rdata = rx_reg;
            A_TXREQ:  rdata = tx_reg;
            A_MDMREQ: rdata = mdm_reg;
            A_CAR:    rdata = car_val;
            A_VIEW:   rdata = active ? {3'b000, ctx_code, ctx_chan} : VIEW_UNDEF;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/svc_poll_ctx.sv
module svc_poll_ctx
    import svc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rx_chan_req,
    input  logic [NCH-1:0] tx_chan_req,
    input  logic [NCH-1:0] mdm_chan_req,
    input  logic           cpu_we,
    input  logic [2:0]     cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    output logic           rx_req_n,
    output logic           tx_req_n,
    output logic           mdm_req_n,
    output logic           ctx_active,
    output logic [1:0]     ctx_type,
    output logic [1:0]     ctx_chan
);
    logic [NCH-1:0]   req_in [NTYPE];
    logic [DW-1:0]    req_reg [NTYPE];
    logic [NTYPE-1:0] valid;
    logic [1:0]       lchan [NTYPE];
    logic [NTYPE-1:0] hit;
    logic [NTYPE-1:0] rel;
    logic [NTYPE-1:0] open_t;
    logic             car_wr;
    logic             close;
    logic             end_match;
    svc_type_e        cur_type;
    logic [DW-1:0]    car_val;
    logic [DW-1:0]    cur_reg;

    assign req_in[0] = rx_chan_req;
    assign req_in[1] = tx_chan_req;
    assign req_in[2] = mdm_chan_req;
    assign car_wr    = cpu_we && (cpu_addr == A_CAR);

    for (genvar t = 0; t < NTYPE; t++) begin : g_type
        assign open_t[t] = ctx_active && (cur_type == svc_type_e'(t));
        assign rel[t]    = close && open_t[t];
        assign hit[t]    = valid[t] && (cpu_wdata == req_reg[t]);

        svc_req_latch #(
            .NCH  (NCH),
            .CODE (type_code(t))
        ) u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .chan_req  (req_in[t]),
            .release_i (rel[t]),
            .open_i    (open_t[t]),
            .valid_o   (valid[t]),
            .chan_o    (lchan[t]),
            .reg_o     (req_reg[t])
        );
    end

    always_comb begin
        cur_reg = req_reg[0];
        if (cur_type == T_TX)  cur_reg = req_reg[1];
        if (cur_type == T_MDM) cur_reg = req_reg[2];
    end

    assign end_match = (cpu_wdata == {2'b00, cur_reg[5:0]});

    svc_ctx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .car_wr    (car_wr),
        .wdata     (cpu_wdata),
        .hit       (hit),
        .end_match (end_match),
        .active_o  (ctx_active),
        .close_o   (close),
        .type_o    (cur_type),
        .chan_o    (ctx_chan),
        .car_o     (car_val)
    );

    svc_read_mux u_rd (
        .addr     (cpu_addr),
        .pending  (valid),
        .rx_reg   (req_reg[0]),
        .tx_reg   (req_reg[1]),
        .mdm_reg  (req_reg[2]),
        .car_val  (car_val),
        .active   (ctx_active),
        .ctx_code (cur_reg[4:2]),
        .ctx_chan (ctx_chan),
        .rdata    (cpu_rdata)
    );

    assign ctx_type  = cur_type;
    assign rx_req_n  = ~valid[0];
    assign tx_req_n  = ~valid[1];
    assign mdm_req_n = ~valid[2];

    logic unused_ok;
    assign unused_ok = ^{lchan[0], lchan[1], lchan[2]};
endmodule

// File: rtl/svc_poll_ctx_chk.sv
module svc_poll_ctx_chk
    import svc_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] rx_chan_req,
    input logic [NCH-1:0] tx_chan_req,
    input logic [NCH-1:0] mdm_chan_req,
    input logic           cpu_we,
    input logic [2:0]     cpu_addr,
    input logic [7:0]     cpu_wdata,
    input logic [7:0]     cpu_rdata,
    input logic           rx_req_n,
    input logic           tx_req_n,
    input logic           mdm_req_n,
    input logic           ctx_active,
    input logic [1:0]     ctx_type,
    input logic [1:0]     ctx_chan
);
    logic [3:0] pins_n;
    logic       car_write;
    assign pins_n    = {1'b1, mdm_req_n, tx_req_n, rx_req_n};
    assign car_write = cpu_we && (cpu_addr == A_CAR);

    AST_STATUS_MIRRORS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == A_STATUS) |-> (cpu_rdata == {5'b0, ~mdm_req_n, ~tx_req_n, ~rx_req_n})); // R3

    AST_VIEW_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_active && cpu_addr == A_VIEW) |-> (cpu_rdata == VIEW_UNDEF)); // R10

    AST_CTX_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_active |-> !pins_n[ctx_type]); // R2

    AST_SWITCH_IGNORED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_active && car_write && cpu_wdata[7]) |=> (ctx_active && $stable(ctx_type) && $stable(ctx_chan))); // R8

    AST_CTX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_active && !car_write) |=> (ctx_active && $stable(ctx_type) && $stable(ctx_chan))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_active && !car_write) |=> !ctx_active); // R7
endmodule

bind svc_poll_ctx svc_poll_ctx_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_svc_poll_ctx.sv
module tb_svc_poll_ctx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_chan_req = '0, tx_chan_req = '0, mdm_chan_req = '0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       rx_req_n, tx_req_n, mdm_req_n, ctx_active;
    logic [1:0] ctx_type, ctx_chan;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    svc_poll_ctx dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [7:0] d);
        cpu_addr  = 3'd4;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        cyc();
        cpu_we    = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rx pin", rx_req_n, 1);
        check("R1 tx pin", tx_req_n, 1);
        check("R1 mdm pin", mdm_req_n, 1);
        check("R1 active", ctx_active, 0);
        chk_reg("R1 status", 3'd0, 8'h00);
        chk_reg("R1 rxreg", 3'd1, 8'h00);
        chk_reg("R1 car", 3'd4, 8'h00);
        chk_reg("R1 view", 3'd5, 8'hFF);
    endtask

    task automatic t_latch();
        rx_chan_req = 4'b1100;
        cyc();
        check("R2 rx pin low", rx_req_n, 0);
        chk_reg("R3 status rx", 3'd0, 8'h01);
        chk_reg("R4 R5 rxreg ch2", 3'd1, 8'h86);
        rx_chan_req = 4'b1110;
        cyc();
        chk_reg("R5 rxreg held", 3'd1, 8'h86);
        tx_chan_req = 4'b0001;
        mdm_chan_req = 4'b1000;
        cyc();
        chk_reg("R4 txreg", 3'd2, 8'h88);
        chk_reg("R4 mdmreg", 3'd3, 8'h93);
        chk_reg("R3 status all", 3'd0, 8'h07);
        chk_reg("R10 view idle", 3'd5, 8'hFF);
    endtask

    task automatic t_bad_switch();
        wr(8'h85);
        check("R7 wrong chan", ctx_active, 0);
        wr(8'h8A);
        check("R7 wrong code", ctx_active, 0);
    endtask

    task automatic t_serve_rx();
        wr(8'h86);
        check("R6 active", ctx_active, 1);
        check("R6 type", ctx_type, 0);
        check("R6 chan", ctx_chan, 2);
        chk_reg("R6 car", 3'd4, 8'h86);
        chk_reg("R4 open bit", 3'd1, 8'hC6);
        chk_reg("R10 view", 3'd5, 8'h06);
        wr(8'h88);
        check("R8 still rx", ctx_type, 0);
        check("R8 chan", ctx_chan, 2);
        wr(8'h05);
        check("R9 wrong close", ctx_active, 1);
        wr(8'h06);
        check("R9 closed", ctx_active, 0);
        check("R9 pin high", rx_req_n, 1);
        chk_reg("R9 cleared", 3'd1, 8'h00);
        cyc();
        chk_reg("R9 relatch ch1", 3'd1, 8'h85);
        rx_chan_req = 4'b0000;
        cyc();
        chk_reg("R5 held after drop", 3'd1, 8'h85);
        wr(8'h85);
        wr(8'h05);
        cyc();
        check("R9 rx idle pin", rx_req_n, 1);
        chk_reg("R9 rx empty", 3'd1, 8'h00);
    endtask

    task automatic t_serve_mdm();
        wr(8'h93);
        check("R6 mdm type", ctx_type, 2);
        check("R6 mdm chan", ctx_chan, 3);
        chk_reg("R10 mdm view", 3'd5, 8'h13);
        wr(8'h13);
        check("R9 mdm closed", ctx_active, 0);
        chk_reg("R10 view after", 3'd5, 8'hFF);
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_latch();
        t_bad_switch();
        t_serve_rx();
        t_serve_mdm();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule